// File: doc/BRIEF.md
# Accumulator round-and-saturate unit

This unit turns a pair of 40-bit accumulators into one rounded, saturated 32-bit signed result. The result comes out as two 16-bit words. The first accumulator supplies the upper part of a 56-bit signed operand. The low 16 bits of the second accumulator fill the bottom of that operand.

The operand goes through a bidirectional shift controlled by a signed amount. Half an LSB is then added, and the low 16 bits are dropped. What remains is read as a 44-bit signed quantity and clamped to the 32-bit signed range.

The unit also handles the overflow flag. When the start strobe is seen, the incoming flag is copied into a secondary "previous" flag. The new overflow flag records whether a clamp took place. All outputs are registered, and a done pulse marks the cycle in which they change.

Top module: `acc_round_sat`

## Requirements
- R1: The operand is {acc_hi_i[39:0], acc_lo_i[15:0]} (56 bits), sign-extended from bit 55 into a 64-bit datapath; bits 39:16 of acc_lo_i have no effect.
- R2: A shift_i value from 0 to 31 (6-bit two's complement) shifts the operand left by that many places, within 64 bits.
- R3: A shift_i value from -1 to -32 shifts the operand right arithmetically by its magnitude.
- R4: After the shift, 0x8000 is added and the sum is shifted right arithmetically by 16. An in-range result is therefore rounded half-up.
- R5: If the rounded value, read as 44-bit signed, is above 0x7FFFFFFF, the unit outputs high word 0x7FFF and low word 0xFFFF and sets ovf_o.
- R6: If that 44-bit signed value is below -0x80000000, the unit outputs high word 0x8000 and low word 0x0000 and sets ovf_o.
- R7: Otherwise, bits 31:16 of the rounded value go to res_hi_o, bits 15:0 go to res_lo_o, and ovf_o is cleared.
- R8: The clamp decision uses only bits 43:0 of the rounded value, which may wrap. For example, a rounded value of 2^43 clamps negative, and a rounded value of 2^44 passes as zero.
- R9: With each start, ovf_prev_o takes the value that ovf_i had at that start.
- R10: Results, flags and done_o change one clock after start_i is high. done_o is high for exactly that cycle. Without start_i, all outputs hold.
- R11: When rst_n is low at a clock edge, both result words, both flags and done_o become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Strobe: capture and convert the inputs this cycle |
| acc_hi_i | input | 40 | Accumulator supplying the operand's upper 40 bits |
| acc_lo_i | input | 40 | Accumulator whose low 16 bits end the operand |
| shift_i | input | 6 | Signed shift amount, two's complement |
| ovf_i | input | 1 | Current overflow flag |
| res_hi_o | output | 16 | Result bits 31:16 or the clamp pattern |
| res_lo_o | output | 16 | Result bits 15:0 or the clamp pattern |
| ovf_o | output | 1 | New overflow flag (clamp occurred) |
| ovf_prev_o | output | 1 | Copy of ovf_i taken at the last start |
| done_o | output | 1 | One-cycle pulse when outputs update |

## Verification
The stimulus is built so that each vector separates one pair of possible mistakes.

- **Rounding:** small values with the low 16 bits just below and just at 0x8000 separate correct round-half-up from plain truncation.
- **Shift direction:** left and right shifts, including the -32 and +31 extremes, catch a swapped direction and a logical right shift used in place of an arithmetic one.
- **Sign extension:** operands with bit 55 set or clear catch a missing sign extension.
- **Clamp width:** shifted values whose rounded form is 2^43 or 2^44 show whether the clamp reads a 44-bit view or the full width.
- **Flags and timing:** idle cycles with changing inputs, flag toggling, and a reset in the middle of the run exercise holding, copying of the previous flag, and clearing.

// File: rtl/acc_rs_pkg.sv
package acc_rs_pkg;
  localparam int ACC_W  = 40;
  localparam int HALF_W = 16;
  localparam int OPND_W = ACC_W + HALF_W;
  localparam int SHIFT_W = 6;
  localparam int DP_W   = 64;
  localparam int CMP_W  = 44;
  localparam int RES_W  = 32;

  // Concatenate and sign-extend the operand from its top bit.
  function automatic logic signed [DP_W-1:0] f_operand(
    input logic [ACC_W-1:0] hi, input logic [ACC_W-1:0] lo);
    logic [OPND_W-1:0] raw;
    raw = {hi, lo[HALF_W-1:0]};
    return {{(DP_W-OPND_W){raw[OPND_W-1]}}, raw};
  endfunction

  // Magnitude of a two's complement shift amount (most negative maps to 2^(W-1)).
  function automatic logic [SHIFT_W-1:0] f_shift_mag(input logic [SHIFT_W-1:0] s);
    return s[SHIFT_W-1] ? (~s + 1'b1) : s;
  endfunction

  // Add half an LSB of the kept part, then drop HALF_W bits.
  function automatic logic signed [DP_W-1:0] f_round(input logic signed [DP_W-1:0] v);
    logic signed [DP_W-1:0] half;
    half = DP_W'(1) <<< (HALF_W-1);
    return (v + half) >>> HALF_W;
  endfunction

  function automatic logic f_over_max(input logic [CMP_W-1:0] view);
    logic signed [CMP_W-1:0] lim;
    lim = {{(CMP_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
    return $signed(view) > lim;
  endfunction

  function automatic logic f_under_min(input logic [CMP_W-1:0] view);
    logic signed [CMP_W-1:0] lim;
    lim = {{(CMP_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};
    return $signed(view) < lim;
  endfunction
endpackage

// File: rtl/acc_rs_operand.sv
module acc_rs_operand
  import acc_rs_pkg::*;
(
  input  logic [ACC_W-1:0]        hi_i,
  input  logic [ACC_W-1:0]        lo_i,
  output logic signed [DP_W-1:0]  opnd_o
);
  always_comb opnd_o = f_operand(hi_i, lo_i);
endmodule

// File: rtl/acc_rs_shifter.sv
module acc_rs_shifter
  import acc_rs_pkg::*;
(
  input  logic signed [DP_W-1:0]  val_i,
  input  logic [SHIFT_W-1:0]      amt_i,
  output logic signed [DP_W-1:0]  val_o
);
  logic                  go_right;
  logic [SHIFT_W-1:0]    mag;
  logic signed [DP_W-1:0] stage [0:SHIFT_W];

  assign go_right = amt_i[SHIFT_W-1];
  assign mag      = f_shift_mag(amt_i);
  assign stage[0] = val_i;

  for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    always_comb begin
      if (!mag[k])
        stage[k+1] = stage[k];
      else if (go_right)
        stage[k+1] = stage[k] >>> STEP;
      else
        stage[k+1] = stage[k] <<< STEP;
    end
  end

  assign val_o = stage[SHIFT_W];
endmodule

// File: rtl/acc_rs_round_sat.sv
module acc_rs_round_sat
  import acc_rs_pkg::*;
(
  input  logic signed [DP_W-1:0] val_i,
  output logic [CMP_W-1:0]       view_o,
  output logic                   sat_pos_o,
  output logic                   sat_neg_o,
  output logic [HALF_W-1:0]      hi_o,
  output logic [HALF_W-1:0]      lo_o
);
  logic signed [DP_W-1:0] rnd;

  always_comb begin
    rnd       = f_round(val_i);
    view_o    = rnd[CMP_W-1:0];
    sat_pos_o = f_over_max(view_o);
    sat_neg_o = f_under_min(view_o);
    if (sat_pos_o) begin
      hi_o = {1'b0, {(HALF_W-1){1'b1}}};
      lo_o = {HALF_W{1'b1}};
    end else if (sat_neg_o) begin
      hi_o = {1'b1, {(HALF_W-1){1'b0}}};
      lo_o = '0;
    end else begin
      hi_o = view_o[RES_W-1:HALF_W];
      lo_o = view_o[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat
  import acc_rs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ACC_W-1:0]    acc_hi_i,
  input  logic [ACC_W-1:0]    acc_lo_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic                ovf_i,
  output logic [HALF_W-1:0]   res_hi_o,
  output logic [HALF_W-1:0]   res_lo_o,
  output logic                ovf_o,
  output logic                ovf_prev_o,
  output logic                done_o
);
  logic signed [DP_W-1:0] opnd_w;
  logic signed [DP_W-1:0] shifted_w;
  logic [CMP_W-1:0]       rnd_view_w;
  logic                   sat_pos_w;
  logic                   sat_neg_w;
  logic [HALF_W-1:0]      nxt_hi_w;
  logic [HALF_W-1:0]      nxt_lo_w;

  acc_rs_operand u_opnd (
    .hi_i   (acc_hi_i),
    .lo_i   (acc_lo_i),
    .opnd_o (opnd_w)
  );

  acc_rs_shifter u_shift (
    .val_i (opnd_w),
    .amt_i (shift_i),
    .val_o (shifted_w)
  );

  acc_rs_round_sat u_rsat (
    .val_i     (shifted_w),
    .view_o    (rnd_view_w),
    .sat_pos_o (sat_pos_w),
    .sat_neg_o (sat_neg_w),
    .hi_o      (nxt_hi_w),
    .lo_o      (nxt_lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_hi_o   <= '0;
      res_lo_o   <= '0;
      ovf_o      <= 1'b0;
      ovf_prev_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        ovf_prev_o <= ovf_i;
        ovf_o      <= sat_pos_w | sat_neg_w;
        res_hi_o   <= nxt_hi_w;
        res_lo_o   <= nxt_lo_w;
      end
    end
  end
endmodule

// File: rtl/acc_round_sat_chk.sv
module acc_round_sat_chk #(
  parameter int HALF_W = 16,
  parameter int CMP_W  = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ovf_i,
  input logic [HALF_W-1:0] res_hi_o,
  input logic [HALF_W-1:0] res_lo_o,
  input logic              ovf_o,
  input logic              ovf_prev_o,
  input logic              done_o,
  input logic [CMP_W-1:0]  rnd_view_w,
  input logic              sat_pos_w,
  input logic              sat_neg_w
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= !rst_n;

  a_r10_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o && $stable(res_hi_o) && $stable(res_lo_o)
                 && $stable(ovf_o) && $stable(ovf_prev_o));

  a_r9_prev_copy: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ovf_prev_o == $past(ovf_i));

  a_r5_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && sat_pos_w |=> ovf_o && res_hi_o == {1'b0, {(HALF_W-1){1'b1}}}
                             && res_lo_o == {HALF_W{1'b1}});

  a_r6_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && sat_neg_w |=> ovf_o && res_hi_o == {1'b1, {(HALF_W-1){1'b0}}}
                             && res_lo_o == '0);

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !sat_pos_w && !sat_neg_w |=> !ovf_o
      && {res_hi_o, res_lo_o} == $past(rnd_view_w[2*HALF_W-1:0]));

  a_r8_one_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sat_pos_w, sat_neg_w}));

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> res_hi_o == '0 && res_lo_o == '0 && !ovf_o && !ovf_prev_o && !done_o);
endmodule

bind acc_round_sat acc_round_sat_chk #(
  .HALF_W (acc_rs_pkg::HALF_W),
  .CMP_W  (acc_rs_pkg::CMP_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ovf_i      (ovf_i),
  .res_hi_o   (res_hi_o),
  .res_lo_o   (res_lo_o),
  .ovf_o      (ovf_o),
  .ovf_prev_o (ovf_prev_o),
  .done_o     (done_o),
  .rnd_view_w (rnd_view_w),
  .sat_pos_w  (sat_pos_w),
  .sat_neg_w  (sat_neg_w)
);

// File: tb/acc_round_sat_tb_top.sv
module acc_round_sat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [39:0] acc_hi_i = '0;
  logic [39:0] acc_lo_i = '0;
  logic [5:0]  shift_i = '0;
  logic        ovf_i = 1'b0;
  logic [15:0] res_hi_o, res_lo_o;
  logic        ovf_o, ovf_prev_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  string cur_tag = "R10";

  always #4 clk = ~clk;

  acc_round_sat dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_hi_i(acc_hi_i),
    .acc_lo_i(acc_lo_i), .shift_i(shift_i), .ovf_i(ovf_i),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .ovf_o(ovf_o),
    .ovf_prev_o(ovf_prev_o), .done_o(done_o)
  );

  // Behavioural reference: plain 64-bit integer arithmetic.
  function automatic longint ref_rounded(logic [39:0] h, logic [39:0] l, int s);
    longint t;
    t = (longint'({24'b0, h}) <<< 16) | longint'({48'b0, l[15:0]});
    t = (t <<< 8) >>> 8;              // R1 sign from bit 55
    if (s >= 0) t = t <<< s;          // R2
    else        t = t >>> (-s);       // R3
    t = (t + 64'sd32768) >>> 16;      // R4
    return t;
  endfunction

  logic [15:0] e_hi = '0, e_lo = '0;
  logic        e_ovf = 0, e_prev = 0, e_done = 0;
  string       e_tag = "R11";

  always @(posedge clk) begin
    longint r, v;
    if (!rst_n) begin
      e_hi = '0; e_lo = '0; e_ovf = 0; e_prev = 0; e_done = 0; e_tag = "R11";
    end else if (start_i) begin
      r = ref_rounded(acc_hi_i, acc_lo_i, int'($signed(shift_i)));
      v = (r <<< 20) >>> 20;          // R8 44-bit view
      e_prev = ovf_i;                 // R9
      e_done = 1;
      if (v > 64'sh7FFFFFFF) begin    // R5
        e_hi = 16'h7FFF; e_lo = 16'hFFFF; e_ovf = 1;
      end else if (v < -64'sh80000000) begin  // R6
        e_hi = 16'h8000; e_lo = 16'h0000; e_ovf = 1;
      end else begin                  // R7
        e_hi = v[31:16]; e_lo = v[15:0]; e_ovf = 0;
      end
      e_tag = cur_tag;
    end else begin
      e_done = 0; e_tag = "R10";
    end
  end

  always @(negedge clk) begin
    if (!ended) begin
      checks++;
      if (res_hi_o !== e_hi || res_lo_o !== e_lo || ovf_o !== e_ovf ||
          ovf_prev_o !== e_prev || done_o !== e_done) begin
        fails++;
        $display("FAIL %s: got hi=%h lo=%h ovf=%b prev=%b done=%b exp hi=%h lo=%h ovf=%b prev=%b done=%b",
                 e_tag, res_hi_o, res_lo_o, ovf_o, ovf_prev_o, done_o,
                 e_hi, e_lo, e_ovf, e_prev, e_done);
      end
    end
  end

  task automatic apply(input logic [39:0] h, input logic [39:0] l,
                       input int s, input logic f, input string tag);
    @(negedge clk); #1;
    acc_hi_i = h; acc_lo_i = l; shift_i = 6'(s); ovf_i = f;
    start_i = 1'b1; cur_tag = tag;
    @(negedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic finish_run;
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: got running exp finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);                     // R11 reset state compared
    #1 rst_n = 1'b1;
    apply(40'h0, 40'h1234, 0, 0, "R4");            // rounds to 0
    apply(40'h1, 40'hAB_0000_8000, 0, 0, "R4");    // half rounds up; R1 upper lo bits ignored
    apply(40'h1, 40'h7FFF, 0, 1, "R4");            // just below half; R9 prev=1
    apply(40'h1234, 40'h0, 4, 0, "R2");
    apply(40'h12, 40'h3456, 31, 1, "R2");          // max left shift
    apply(40'h12_3400, 40'h0, -8, 0, "R3");
    apply(40'hFF_FFFF_FFFF, 40'h0, 0, 0, "R1");    // -65536 -> -1
    apply(40'hF0_0000_0000, 40'h0, -32, 0, "R3");  // arithmetic right, most negative amount
    apply(40'h7F_FFFF_FFFF, 40'hFFFF, 0, 0, "R5");
    apply(40'h80_0000_0000, 40'h0, 0, 1, "R6");    // bit 55 set
    apply(40'h40_0000_0000, 40'h0, 5, 0, "R8");    // 2^43 clamps negative
    apply(40'h40_0000_0000, 40'h0, 6, 1, "R8");    // 2^44 passes as zero
    apply(40'h0, 40'h7FFF_8000, 0, 0, "R7");
    apply(40'hFF_8000_0000, 40'h0, 0, 0, "R7");    // exactly -2^31 in range
    apply(40'h00_7FFF_FFFF, 40'h7FFF, 0, 0, "R7"); // exactly max in range
    for (int i = 0; i < 6; i++) begin              // R10 idle with moving inputs
      @(negedge clk); #1;
      acc_hi_i = 40'h7F_0000_0000 ^ 40'(i); shift_i = 6'(i); ovf_i = i[0];
    end
    for (int i = 0; i < 20; i++)
      apply(40'(64'h9E37_79B9_7F4A_7C15 * (i + 1)), 40'(64'hC2B2_AE35 * (i + 3)),
            (i * 7) % 64 - 32, i[1], "R7");
    apply(40'h7F_FFFF_FFFF, 40'h0, 0, 1, "R5");
    @(negedge clk); #1 rst_n = 1'b0;               // R11 mid-run reset
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 finish_run();
  end
endmodule